// File: doc/BRIEF.md
# Prescaled Auto-Reload Down-Counter Timer

This block is a word-addressed countdown timer. Software writes a start value, selects a clock divider and one of two ending behaviours, then sets the enable bit. While enabled, the counter steps down once per divided period. When it reaches its end, a sticky expiry flag is raised and drives a level interrupt line. In auto-reload mode the counter restarts from the stored start value. In one-shot mode it parks at zero. Software acknowledges the interrupt by writing a one to the flag.

Sequencing is held in a three-state machine. `ST_OFF` means the enable bit is clear. `ST_RUN` means the block is enabled with a non-zero count. `ST_IDLE` means the block is enabled with a zero count. The transitions are:
- arm: `ST_OFF` to `ST_RUN`, on enable with a non-zero count.
- park: `ST_OFF` to `ST_IDLE`, on enable with a zero count.
- drain: `ST_RUN` to `ST_IDLE`, on a one-shot expiry or when zero is written.
- wake: `ST_IDLE` to `ST_RUN`, when a non-zero count is written or copied.
- halt: any state to `ST_OFF`, on disable.

The bus is a single-cycle select/write port. Read data is combinational from the current register state. A write takes effect at the next rising clock edge.

Top module: `prescaled_reload_timer`

## Requirements
- R1: After reset, the start value, counter, control and flag registers are all zero, and `irq` is low.
- R2: Word offsets are 0x00 start value, 0x04 counter, 0x08 control and 0x0C flag. Any other address in the 32-byte window, and any address with bits 1:0 non-zero, reads as zero and ignores writes.
- R3: Control bit 0 is enable, bit 1 is auto-reload and bits 15:8 are the divider P. All other control bits read back as zero.
- R4: While enabled with a non-zero count, the counter drops by one every P+1 clocks. The first decrement lands P+1 clocks after the edge that enabled it. While disabled, the counter holds.
- R5: A write to offset 0x00 stores the start value and also places it in the counter. A write to 0x04 changes only the counter.
- R6: A counter or start-value write while enabled restarts the divider phase, so the next decrement is a full P+1 clocks later.
- R7: A decrement from 1 is an expiry, and sets the flag. With auto-reload, the counter takes the start value and keeps counting. Otherwise it stays at zero.
- R8: On a 0-to-1 enable write with auto-reload set and a zero counter, the counter first takes the start value.
- R9: A read of offset 0x04 returns zero while enable is clear, whatever count is held.
- R10: An enabled counter holding zero neither counts nor expires.
- R11: Writing 1 to bit 0 of 0x0C clears the flag. Writing 0 leaves it unchanged. `irq` always equals the flag, which reads back in bit 0.
- R12: When a flag clear and an expiry fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (zero when not reading) |
| irq | output | 1 | Level interrupt, equal to the expiry flag |

## Verification
Read data is due in the same cycle as the request. A register write is visible in the cycle after its clock edge. The first decrement is due P+1 edges after the enabling edge. The flag, and with it `irq`, rises on the edge that performs the expiring decrement. The bench keeps a behavioural model that is updated on every rising edge from the same sampled inputs. One nanosecond after each falling edge it compares `irq`, and any read data, against that model, so every result is checked in exactly the cycle it is due. The stimulus is arranged so that status clears land on expiry edges, and so that counter writes land mid-period.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_IDLE = 2'd2
    } ptmr_state_e;

    // word indices inside the register window
    localparam int unsigned REG_LOAD  = 0;
    localparam int unsigned REG_COUNT = 1;
    localparam int unsigned REG_CTRL  = 2;
    localparam int unsigned REG_STAT  = 3;

    // control field positions
    localparam int unsigned CTRL_EN_BIT  = 0;
    localparam int unsigned CTRL_RL_BIT  = 1;
    localparam int unsigned CTRL_DIV_LSB = 8;

endpackage

// File: rtl/ptmr_prescale.sv
module ptmr_prescale #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] phase_q;

    // >= keeps the divider sane if the divider value shrinks mid-period
    assign tick = run && (phase_q >= div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart || !run || tick) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + DIV_W'(1);
        end
    end

    // R4: a tick with a non-zero divider is never followed at once by another
    p_tick_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick && (div != '0) |=> !tick || (div == '0));

    // R6: after a restart the divider starts a full period
    p_restart_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
        restart && run && (div != '0) |=> !tick || (div == '0) || restart);

endmodule

// File: rtl/ptmr_core.sv
module ptmr_core
    import ptmr_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_load,
    input  logic             wr_cnt,
    input  logic [CNT_W-1:0] wdata,
    input  logic             en_q,
    input  logic             en_next,
    input  logic             en_rise,
    input  logic             rl_q,
    input  logic             rl_next,
    input  logic [CNT_W-1:0] load_q,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt_q,
    output logic             expire,
    output logic             run
);

    ptmr_state_e      state_q, state_n;
    logic [CNT_W-1:0] cnt_n;
    logic             cnt_zero_n;
    logic             wr_any_cnt;
    logic             reload_copy;

    assign wr_any_cnt  = wr_load || wr_cnt;
    assign reload_copy = en_rise && rl_next && (cnt_q == '0);

    // output process: state decodes
    always_comb begin
        run    = (state_q == ST_RUN);
        expire = run && tick && !wr_any_cnt && (cnt_q == CNT_W'(1));
    end

    // next count
    always_comb begin
        cnt_n = cnt_q;
        if (wr_any_cnt) begin
            cnt_n = wdata;
        end else if (reload_copy) begin
            cnt_n = load_q;
        end else if (run && tick) begin
            if (cnt_q == CNT_W'(1)) begin
                cnt_n = rl_q ? load_q : '0;
            end else begin
                cnt_n = cnt_q - CNT_W'(1);
            end
        end
    end

    assign cnt_zero_n = (cnt_n == '0);

    // next state, transitions named arm/park/drain/wake/halt
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (en_next) begin
                    state_n = cnt_zero_n ? ST_IDLE : ST_RUN;   // park / arm
                end
            end
            ST_RUN: begin
                if (!en_next) begin
                    state_n = ST_OFF;                          // halt
                end else if (cnt_zero_n) begin
                    state_n = ST_IDLE;                         // drain
                end
            end
            ST_IDLE: begin
                if (!en_next) begin
                    state_n = ST_OFF;                          // halt
                end else if (!cnt_zero_n) begin
                    state_n = ST_RUN;                          // wake
                end
            end
            default: state_n = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_n;
        end
    end

    // R10: the state register tracks the enable bit and the count
    p_run_matches_r10: assert property (@(posedge clk) disable iff (!rst_n)
        en_q && (cnt_q != '0) |-> state_q == ST_RUN);

    // R10: an enabled zero count never expires
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0) |-> !expire);

    // R4: with nothing running and no write, the count holds
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !wr_any_cnt && !en_rise |=> $stable(cnt_q));

    // R7: reload and one-shot endings
    p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        expire && rl_q |=> cnt_q == $past(load_q));
    p_oneshot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        expire && !rl_q |=> cnt_q == '0);

endmodule

// File: rtl/ptmr_regs.sv
module ptmr_regs
    import ptmr_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DIV_W  = 8,
    parameter int unsigned ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] cnt_q,
    input  logic              expire,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wr_load,
    output logic              wr_cnt,
    output logic [DATA_W-1:0] load_q,
    output logic              en_q,
    output logic              en_next,
    output logic              en_rise,
    output logic              rl_q,
    output logic              rl_next,
    output logic [DIV_W-1:0]  div_q,
    output logic              irq
);

    localparam int unsigned IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             aligned;
    logic             wr_ok;
    logic             wr_ctrl;
    logic             wr_stat;
    logic             stat_q;
    logic [DATA_W-1:0] ctrl_view;

    assign idx     = bus_addr[ADDR_W-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign wr_ok   = bus_sel && bus_wr && aligned;
    assign wr_load = wr_ok && (idx == IDX_W'(REG_LOAD));
    assign wr_cnt  = wr_ok && (idx == IDX_W'(REG_COUNT));
    assign wr_ctrl = wr_ok && (idx == IDX_W'(REG_CTRL));
    assign wr_stat = wr_ok && (idx == IDX_W'(REG_STAT));

    assign en_next = wr_ctrl ? bus_wdata[CTRL_EN_BIT] : en_q;
    assign rl_next = wr_ctrl ? bus_wdata[CTRL_RL_BIT] : rl_q;
    assign en_rise = wr_ctrl && bus_wdata[CTRL_EN_BIT] && !en_q;
    assign irq     = stat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q <= '0;
            en_q   <= 1'b0;
            rl_q   <= 1'b0;
            div_q  <= '0;
        end else begin
            if (wr_load) begin
                load_q <= bus_wdata;
            end
            if (wr_ctrl) begin
                en_q  <= bus_wdata[CTRL_EN_BIT];
                rl_q  <= bus_wdata[CTRL_RL_BIT];
                div_q <= bus_wdata[CTRL_DIV_LSB +: DIV_W];
            end
        end
    end

    // expiry takes priority over an acknowledge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= 1'b0;
        end else if (expire) begin
            stat_q <= 1'b1;
        end else if (wr_stat && bus_wdata[0]) begin
            stat_q <= 1'b0;
        end
    end

    always_comb begin
        ctrl_view = '0;
        ctrl_view[CTRL_EN_BIT] = en_q;
        ctrl_view[CTRL_RL_BIT] = rl_q;
        ctrl_view[CTRL_DIV_LSB +: DIV_W] = div_q;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr && aligned) begin
            unique case (idx)
                IDX_W'(REG_LOAD):  bus_rdata = load_q;
                IDX_W'(REG_COUNT): bus_rdata = en_q ? cnt_q : '0;
                IDX_W'(REG_CTRL):  bus_rdata = ctrl_view;
                IDX_W'(REG_STAT):  bus_rdata = {{(DATA_W-1){1'b0}}, stat_q};
                default:           bus_rdata = '0;
            endcase
        end
    end

    // R12: an expiry always leaves the flag set
    p_expire_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> irq);

    // R11: an acknowledge without a coincident expiry drops the line
    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat && bus_wdata[0] && !expire |=> !irq);

    // R2: misaligned reads return zero
    p_misaligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && !bus_wr && !aligned |-> bus_rdata == '0);

    // R9: counter reads while disabled return zero
    p_count_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && !bus_wr && aligned && (idx == IDX_W'(REG_COUNT)) && !en_q
        |-> bus_rdata == '0);

endmodule

// File: rtl/prescaled_reload_timer.sv
module prescaled_reload_timer #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DIV_W  = 8,
    parameter int unsigned ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    logic              wr_load, wr_cnt;
    logic [DATA_W-1:0] load_q, cnt_q;
    logic              en_q, en_next, en_rise, rl_q, rl_next;
    logic [DIV_W-1:0]  div_q;
    logic              tick, expire, run, restart;

    assign restart = en_rise || ((wr_load || wr_cnt) && en_q);

    ptmr_regs #(
        .DATA_W (DATA_W),
        .DIV_W  (DIV_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cnt_q     (cnt_q),
        .expire    (expire),
        .bus_rdata (bus_rdata),
        .wr_load   (wr_load),
        .wr_cnt    (wr_cnt),
        .load_q    (load_q),
        .en_q      (en_q),
        .en_next   (en_next),
        .en_rise   (en_rise),
        .rl_q      (rl_q),
        .rl_next   (rl_next),
        .div_q     (div_q),
        .irq       (irq)
    );

    ptmr_prescale #(
        .DIV_W (DIV_W)
    ) u_prescale (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (restart),
        .div     (div_q),
        .tick    (tick)
    );

    ptmr_core #(
        .CNT_W (DATA_W)
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_load (wr_load),
        .wr_cnt  (wr_cnt),
        .wdata   (bus_wdata),
        .en_q    (en_q),
        .en_next (en_next),
        .en_rise (en_rise),
        .rl_q    (rl_q),
        .rl_next (rl_next),
        .load_q  (load_q),
        .tick    (tick),
        .cnt_q   (cnt_q),
        .expire  (expire),
        .run     (run)
    );

endmodule

// File: tb/prescaled_reload_timer_bench.sv
module prescaled_reload_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sel, wr;
    logic [4:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        irq;

    int    checks = 0;
    int    errors = 0;
    int    cyc    = 0;
    string cur_req = "R1";

    // behavioural reference state
    logic [31:0] m_load, m_cnt;
    logic        m_en, m_rl, m_stat;
    int          m_div, m_phase;

    always #2 clk = ~clk;   // 250 MHz

    prescaled_reload_timer u_prescaled_reload_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (sel),
        .bus_wr    (wr),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .irq       (irq)
    );

    always @(posedge clk) begin : ref_model
        logic al, wl, wc, wk, ws, running, tk, ex, rise;
        logic [31:0] ncnt;
        if (!rst_n) begin
            m_load = 0; m_cnt = 0; m_en = 0; m_rl = 0; m_stat = 0;
            m_div = 0; m_phase = 0;
        end else begin
            al = sel && wr && (addr[1:0] == 2'b00);
            wl = al && (addr[4:2] == 3'd0);
            wc = al && (addr[4:2] == 3'd1);
            wk = al && (addr[4:2] == 3'd2);
            ws = al && (addr[4:2] == 3'd3);
            running = m_en && (m_cnt != 0);
            tk = running && (m_phase >= m_div);
            rise = wk && wdata[0] && !m_en;
            ex = 1'b0;
            ncnt = m_cnt;
            if (wl || wc) ncnt = wdata;
            else if (rise && wdata[1] && m_cnt == 0) ncnt = m_load;
            else if (tk) begin
                if (m_cnt == 1) begin
                    ex = 1'b1;
                    ncnt = m_rl ? m_load : 32'd0;
                end else begin
                    ncnt = m_cnt - 1;
                end
            end
            if (rise || ((wl || wc) && m_en) || !running || tk) m_phase = 0;
            else m_phase = m_phase + 1;
            if (ex) m_stat = 1'b1;
            else if (ws && wdata[0]) m_stat = 1'b0;
            if (wl) m_load = wdata;
            if (wk) begin
                m_en = wdata[0];
                m_rl = wdata[1];
                m_div = int'(wdata[15:8]);
            end
            m_cnt = ncnt;
        end
    end

    function automatic logic [31:0] exp_read();
        if (addr[1:0] != 2'b00) return 32'd0;
        case (addr[4:2])
            3'd0: return m_load;
            3'd1: return m_en ? m_cnt : 32'd0;
            3'd2: return {16'd0, 8'(m_div), 6'd0, m_rl, m_en};
            3'd3: return {31'd0, m_stat};
            default: return 32'd0;
        endcase
    endfunction

    always @(negedge clk) begin
        #1;
        checks++;
        if (irq !== m_stat) begin
            errors++;
            $display("FAIL %s (irq, R11): actual %0d expected %0d", cur_req, irq, m_stat);
        end
        if (sel && !wr) begin
            checks++;
            if (rdata !== exp_read()) begin
                errors++;
                $display("FAIL %s read @%0h: actual %08h expected %08h",
                         cur_req, addr, rdata, exp_read());
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic bw(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    endtask

    task automatic br(input logic [4:0] a);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a; wdata = 32'd0;
    endtask

    task automatic poll(input int n);
        for (int i = 0; i < n; i++) br(5'h04);
    endtask

    initial begin
        rst_n = 1'b0; sel = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        cur_req = "R1";
        br(5'h00); br(5'h04); br(5'h08); br(5'h0C);
        // R2 unmapped and misaligned accesses
        cur_req = "R2";
        bw(5'h10, 32'hFFFF_FFFF); bw(5'h1C, 32'h1234); bw(5'h01, 32'h55);
        bw(5'h0A, 32'h3);
        br(5'h10); br(5'h14); br(5'h18); br(5'h1C); br(5'h01); br(5'h00); br(5'h08);
        // R3 control fields
        cur_req = "R3";
        bw(5'h08, 32'hFFFF_FFFC); br(5'h08);
        bw(5'h08, 32'h0); br(5'h08);
        // R5 and R9 writes while disabled
        cur_req = "R5";
        bw(5'h00, 32'd7); br(5'h00);
        cur_req = "R9";
        br(5'h04);
        cur_req = "R5";
        bw(5'h04, 32'd3); br(5'h00);
        // R4 divided counting, one-shot
        cur_req = "R4";
        bw(5'h08, 32'h0000_0201); poll(9);
        cur_req = "R7";
        poll(5);
        // R11 acknowledge
        cur_req = "R11";
        bw(5'h0C, 32'h0); br(5'h0C); bw(5'h0C, 32'h1); br(5'h0C);
        // R7 auto-reload
        cur_req = "R7";
        bw(5'h08, 32'h0); bw(5'h00, 32'd4); bw(5'h08, 32'h3); poll(14);
        // R12 clear colliding with expiry
        cur_req = "R12";
        for (int i = 0; i < 12; i++) bw(5'h0C, 32'h1);
        br(5'h0C);
        // R6 restart of the phase on writes while enabled
        cur_req = "R6";
        bw(5'h08, 32'h0); bw(5'h0C, 32'h1); bw(5'h00, 32'd20);
        bw(5'h08, 32'h0000_0301); poll(5);
        bw(5'h04, 32'd10); poll(6);
        bw(5'h00, 32'd3); poll(14);
        // R9 disable mid-count
        cur_req = "R9";
        bw(5'h08, 32'h0000_0101); bw(5'h04, 32'd50); poll(3);
        bw(5'h08, 32'h2); poll(3);
        // R8 enable edge copies the start value
        cur_req = "R8";
        bw(5'h0C, 32'h1); bw(5'h00, 32'd6); bw(5'h04, 32'd0);
        bw(5'h08, 32'h3); poll(4);
        // R10 zero count enabled, one-shot enable
        cur_req = "R10";
        bw(5'h08, 32'h0); bw(5'h0C, 32'h1); bw(5'h04, 32'd0);
        bw(5'h08, 32'h1); poll(10);
        bw(5'h08, 32'h0); bw(5'h04, 32'd5); bw(5'h08, 32'h1); poll(2);
        bw(5'h04, 32'd0); poll(10);
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
        repeat (3) @(negedge clk);
        #2;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule